// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

The core runs a compact subset of a classic three-operand, 32-bit load/store instruction set. Each instruction completes in one clock cycle. On every rising edge the core fetches the word at the program counter and decodes it as one of three layouts: register, immediate or jump. It reads two operands from a 32-entry register file, computes the result and, on the same edge, updates the register file, the data array and the program counter.

Programs are placed in an internal word-indexed instruction array through a write port. This is normally done while reset is held. Data loads and stores use a separate internal word array. A debug port shows the current program counter together with the register write that the last executed instruction committed. An observer can therefore follow execution one instruction at a time.

Top module: `risc32_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `dbg_pc` is 0 and `dbg_wb_valid` is 0. Reset also clears every register to 0. The data array keeps its contents.
- R2: When the executed instruction is not a branch or a jump, the PC advances by 4. The instruction is fetched from array word `pc[7:2]` (the index wraps for the default 64 words). An all-zero word changes nothing except the PC, and so do unknown opcodes and unknown function codes.
- R3: Register format (opcode 0) uses fields op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. The function codes are add 32, sub 34, and 36, or 37, nor 39 and slt 42. Each writes `rd` from `rs` and `rt`. slt writes 1 when `rs` is less than `rt` as signed values, and 0 otherwise.
- R4: Function code 0 shifts `rt` left logically by `shamt`. Function code 2 shifts it right logically. The value of `rs` has no effect on either shift.
- R5: Each immediate form writes `rt` from `rs` and imm[15:0]. addi (8) and slti (10, signed compare) sign-extend the immediate. andi (12) and ori (13) zero-extend it. lui (15) writes the immediate to bits 31:16 and zeros to bits 15:0.
- R6: lw (35) writes `rt` from the data word at byte address `rs` + sign-extended imm. sw (43) stores `rt` at that address. The word is selected by address bits [7:2]. A store writes no register.
- R7: beq (4) branches when `rs` equals `rt`, and bne (5) branches when they differ. A taken branch sets the PC to PC+4 plus the sign-extended word offset times 4. A branch that is not taken falls through to PC+4.
- R8: j (2) sets the PC to bits 31:28 of PC+4, followed by the 26-bit field, followed by two zero bits. A field of 1212 therefore reaches byte 4848.
- R9: Register 0 always reads as 0. Any instruction that targets register 0 changes no state and reports no debug write.
- R10: After each rising edge, `dbg_pc` shows the new PC. `dbg_wb_valid`, `dbg_wb_addr` and `dbg_wb_data` show the register write committed on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Write strobe for the instruction array |
| imem_waddr | input | 6 | Word index to write |
| imem_wdata | input | 32 | Instruction word to write |
| dbg_pc | output | 32 | Current program counter |
| dbg_wb_valid | output | 1 | A register write was committed on the last edge |
| dbg_wb_addr | output | 5 | Index of the register written |
| dbg_wb_data | output | 32 | Value written |

## Verification
Control transfers that leave the loaded program are the hardest case to reach from the ports. Examples are a jump far beyond the array, which makes the fetch index wrap, and a backward branch with a negative word offset. A directed program reaches them with a jump field of 1212, a negative-offset branch placed at the wrapped word, and a store through a base register with a negative offset. Random programs then mix every opcode with short forward and backward branches over a small register set, so that equal operands, and therefore taken branches, occur often. A reference model in the bench follows each one instruction at a time.

// File: rtl/risc32_pkg.sv
package risc32_pkg;
  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_SLTI  = 6'd10;
  localparam logic [5:0] OP_ANDI  = 6'd12;
  localparam logic [5:0] OP_ORI   = 6'd13;
  localparam logic [5:0] OP_LUI   = 6'd15;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_SLL = 6'd0;
  localparam logic [5:0] FN_SRL = 6'd2;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_NOR = 6'd39;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
    ALU_SLT, ALU_SLL, ALU_SRL, ALU_LUI
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    use_imm;
    logic    imm_zext;
    logic    mem_rd;
    logic    mem_wr;
    logic    branch;
    logic    branch_ne;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/risc32_decode.sv
module risc32_decode
  import risc32_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);
  logic [5:0] op;
  logic [5:0] fn;
  assign op = instr[31:26];
  assign fn = instr[5:0];

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (op)
      OP_RTYPE: begin
        ctrl.reg_we = 1'b1;
        ctrl.dst_rd = 1'b1;
        unique case (fn)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_NOR:  ctrl.alu_op = ALU_NOR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          FN_SLL:  ctrl.alu_op = ALU_SLL;
          FN_SRL:  ctrl.alu_op = ALU_SRL;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OP_ADDI: begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; end
      OP_SLTI: begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_SLT; end
      OP_ANDI: begin
        ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1; ctrl.alu_op = ALU_AND;
      end
      OP_ORI: begin
        ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1; ctrl.alu_op = ALU_OR;
      end
      OP_LUI: begin
        ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1; ctrl.alu_op = ALU_LUI;
      end
      OP_LW:  begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.mem_rd = 1'b1; end
      OP_SW:  begin ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1; end
      OP_BEQ: ctrl.branch = 1'b1;
      OP_BNE: begin ctrl.branch = 1'b1; ctrl.branch_ne = 1'b1; end
      OP_J:   ctrl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/risc32_alu.sv
module risc32_alu
  import risc32_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [4:0]      shamt,
  output logic [XLEN-1:0] y
);
  localparam int HALF = XLEN / 2;

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOR: y = ~(a | b);
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLL: y = b << shamt;
      ALU_SRL: y = b >> shamt;
      ALU_LUI: y = {b[HALF-1:0], {HALF{1'b0}}};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/risc32_regfile.sv
module risc32_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NREGS)-1:0] ra1,
  input  logic [$clog2(NREGS)-1:0] ra2,
  output logic [XLEN-1:0]          rd1,
  output logic [XLEN-1:0]          rd2,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] wa,
  input  logic [XLEN-1:0]          wd
);
  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/risc32_core.sv
module risc32_core
  import risc32_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int IAW = $clog2(IMEM_WORDS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           imem_we,
  input  logic [IAW-1:0] imem_waddr,
  input  logic [31:0]    imem_wdata,
  output logic [31:0]    dbg_pc,
  output logic           dbg_wb_valid,
  output logic [4:0]     dbg_wb_addr,
  output logic [31:0]    dbg_wb_data
);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] pc_q;
  logic        run_q;
  logic [31:0] instr;
  ctrl_t       ctrl;
  logic [4:0]  f_rs, f_rt, f_rd, f_sh;
  logic [31:0] imm_s, imm_z, rs_val, rt_val, op_b, alu_y, load_w, wb_data;
  logic [4:0]  wb_addr;
  logic        wb_en, br_taken, is_jump, is_flow, is_store, is_lui, is_slt;
  logic [31:0] pc_plus4, br_target, j_target, pc_next;
  logic [DAW-1:0] d_idx;

  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_waddr] <= imem_wdata;
  end
  assign instr = imem[pc_q[IAW+1:2]];

  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_sh  = instr[10:6];
  assign imm_s = {{16{instr[15]}}, instr[15:0]};
  assign imm_z = {16'h0, instr[15:0]};

  risc32_decode u_dec (.instr(instr), .ctrl(ctrl));

  risc32_regfile #(.XLEN(32), .NREGS(32)) u_rf (
    .clk(clk), .rst(rst), .ra1(f_rs), .ra2(f_rt), .rd1(rs_val), .rd2(rt_val),
    .we(wb_en), .wa(wb_addr), .wd(wb_data)
  );

  assign op_b = ctrl.use_imm ? (ctrl.imm_zext ? imm_z : imm_s) : rt_val;

  risc32_alu #(.XLEN(32)) u_alu (
    .op(ctrl.alu_op), .a(rs_val), .b(op_b), .shamt(f_sh), .y(alu_y)
  );

  assign d_idx  = alu_y[DAW+1:2];
  assign load_w = dmem[d_idx];
  always_ff @(posedge clk) begin
    if (ctrl.mem_wr && !rst) dmem[d_idx] <= rt_val;
  end

  assign wb_data = ctrl.mem_rd ? load_w : alu_y;
  assign wb_addr = ctrl.dst_rd ? f_rd : f_rt;
  assign wb_en   = ctrl.reg_we && !rst;

  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + {imm_s[29:0], 2'b00};
  assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign br_taken  = ctrl.branch && ((rs_val == rt_val) != ctrl.branch_ne);
  assign pc_next   = ctrl.jump ? j_target : (br_taken ? br_target : pc_plus4);

  assign is_jump  = ctrl.jump;
  assign is_flow  = ctrl.jump || ctrl.branch;
  assign is_store = ctrl.mem_wr;
  assign is_lui   = ctrl.reg_we && (ctrl.alu_op == ALU_LUI);
  assign is_slt   = ctrl.alu_op == ALU_SLT;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q         <= '0;
      run_q        <= 1'b0;
      dbg_wb_valid <= 1'b0;
      dbg_wb_addr  <= '0;
      dbg_wb_data  <= '0;
    end else begin
      pc_q         <= pc_next;
      run_q        <= 1'b1;
      dbg_wb_valid <= wb_en && (wb_addr != 5'd0);
      dbg_wb_addr  <= wb_addr;
      dbg_wb_data  <= wb_data;
    end
  end
  assign dbg_pc = pc_q;

  p_reset_state_r1: assert property (@(posedge clk) rst |=> (dbg_pc == 32'd0 && !dbg_wb_valid))
    else $error("reset state not reached");
  p_pc_aligned_r2: assert property (@(posedge clk) disable iff (rst) dbg_pc[1:0] == 2'b00)
    else $error("misaligned pc");
  p_seq_advance_r2: assert property (@(posedge clk) disable iff (rst)
      (run_q && !$past(is_flow)) |-> dbg_pc == $past(dbg_pc) + 32'd4)
    else $error("pc did not advance by 4");
  p_slt_boolean_r3: assert property (@(posedge clk) disable iff (rst) is_slt |-> alu_y[31:1] == '0)
    else $error("compare result not 0/1");
  p_lui_low_zero_r5: assert property (@(posedge clk) disable iff (rst) is_lui |-> wb_data[15:0] == 16'h0)
    else $error("upper-immediate low half not zero");
  p_store_no_wb_r6: assert property (@(posedge clk) disable iff (rst)
      (run_q && $past(is_store)) |-> !dbg_wb_valid)
    else $error("store reported a register write");
  p_jump_field_r8: assert property (@(posedge clk) disable iff (rst)
      (run_q && $past(is_jump)) |-> dbg_pc[27:2] == $past(instr[25:0]))
    else $error("jump target mismatch");
  p_no_zero_write_r9: assert property (@(posedge clk) disable iff (rst) dbg_wb_valid |-> dbg_wb_addr != 5'd0)
    else $error("write to register 0 reported");
endmodule

// File: tb/risc32_core_tb.sv
`timescale 1ns/1ps
module risc32_core_tb;
  localparam int IW = 64;
  localparam int DW = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_waddr = '0;
  logic [31:0] imem_wdata = '0;
  logic [31:0] dbg_pc;
  logic        dbg_wb_valid;
  logic [4:0]  dbg_wb_addr;
  logic [31:0] dbg_wb_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] prog  [IW];
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [DW];
  logic [31:0] m_pc;
  logic [31:0] e_pc;
  logic        e_valid;
  logic [4:0]  e_addr;
  logic [31:0] e_data;
  string       e_tag;

  always #10 clk = ~clk;

  risc32_core u_dut (
    .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .dbg_pc(dbg_pc), .dbg_wb_valid(dbg_wb_valid),
    .dbg_wb_addr(dbg_wb_addr), .dbg_wb_data(dbg_wb_data)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int tgt);
    return {6'd2, 26'(tgt)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (pc=%h)", tag, act, exp, m_pc);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0;
  endtask

  task automatic model_step();
    logic [31:0] ins, a, b, se, ze, res, addr;
    logic [5:0] op, fn;
    logic [4:0] rs, rt, rd, sh, dst;
    logic wr;
    ins = prog[m_pc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; sh = ins[10:6];
    a = m_reg[rs]; b = m_reg[rt];
    se = {{16{ins[15]}}, ins[15:0]};
    ze = {16'h0, ins[15:0]};
    e_pc = m_pc + 4; wr = 1'b0; dst = rt; res = '0; e_tag = "R2";
    case (op)
      6'd0: begin
        dst = rd; wr = 1'b1; e_tag = "R3";
        case (fn)
          6'd32: res = a + b;
          6'd34: res = a - b;
          6'd36: res = a & b;
          6'd37: res = a | b;
          6'd39: res = ~(a | b);
          6'd42: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          6'd0:  begin res = b << sh; e_tag = "R4"; end
          6'd2:  begin res = b >> sh; e_tag = "R4"; end
          default: begin wr = 1'b0; e_tag = "R2"; end
        endcase
        if (ins == 32'h0) e_tag = "R2";
      end
      6'd8:  begin wr = 1'b1; res = a + se; e_tag = "R5"; end
      6'd10: begin wr = 1'b1; res = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0; e_tag = "R5"; end
      6'd12: begin wr = 1'b1; res = a & ze; e_tag = "R5"; end
      6'd13: begin wr = 1'b1; res = a | ze; e_tag = "R5"; end
      6'd15: begin wr = 1'b1; res = {ins[15:0], 16'h0}; e_tag = "R5"; end
      6'd35: begin addr = a + se; wr = 1'b1; res = m_mem[addr[7:2]]; e_tag = "R6"; end
      6'd43: begin addr = a + se; m_mem[addr[7:2]] = b; e_tag = "R6"; end
      6'd4:  begin if (a == b) e_pc = m_pc + 4 + {se[29:0], 2'b00}; e_tag = "R7"; end
      6'd5:  begin if (a != b) e_pc = m_pc + 4 + {se[29:0], 2'b00}; e_tag = "R7"; end
      6'd2:  begin e_pc = {m_pc[31:28] + 4'(((m_pc + 4) >> 28) - (m_pc >> 28)), ins[25:0], 2'b00};
                   e_tag = "R8"; end
      default: ;
    endcase
    e_valid = wr && (dst != 5'd0);
    if (wr && dst == 5'd0) e_tag = "R9";
    e_addr = dst; e_data = res;
    if (e_valid) m_reg[dst] = res;
    m_pc = e_pc;
  endtask

  task automatic load_prog();
    for (int i = 0; i < IW; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_waddr = 6'(i); imem_wdata = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
  endtask

  task automatic run(int n);
    for (int c = 0; c < n; c++) begin
      model_step();
      @(posedge clk);
      @(negedge clk);
      check({e_tag, "/R10 pc"}, dbg_pc, e_pc);
      check({e_tag, "/R10 valid"}, {31'd0, dbg_wb_valid}, {31'd0, e_valid});
      if (e_valid && dbg_wb_valid) begin
        check({e_tag, "/R10 addr"}, {27'd0, dbg_wb_addr}, {27'd0, e_addr});
        check({e_tag, "/R10 data"}, dbg_wb_data, e_data);
      end
    end
  endtask

  task automatic reset_and_check(int cycles);
    rst = 1'b1;
    for (int c = 0; c < cycles; c++) @(negedge clk);
    check("R1 pc in reset", dbg_pc, 32'd0);
    check("R1 valid in reset", {31'd0, dbg_wb_valid}, 32'd0);
    rst = 1'b0;
    model_reset();
  endtask

  function automatic logic [31:0] rand_instr();
    int k, rs, rt, rd;
    int fns [8] = '{32, 34, 36, 37, 39, 42, 0, 2};
    int ops [5] = '{8, 10, 12, 13, 15};
    k = $urandom % 12;
    rs = $urandom % 8; rt = $urandom % 8; rd = $urandom % 8;
    case (k)
      0, 1, 2, 3: return enc_r(rs, rt, rd, $urandom % 32, fns[$urandom % 8]);
      4, 5, 6:    return enc_i(ops[$urandom % 5], rs, rt, $urandom % 65536);
      7:          return enc_i(35, 0, rt, ($urandom % 16) * 4);
      8:          return enc_i(43, 0, rt, ($urandom % 16) * 4);
      9:          return enc_i(($urandom % 2) ? 5 : 4, rs % 4, rt % 4, int'($urandom % 9) - 4);
      10:         return enc_j($urandom % IW);
      default:    return 32'h0;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DW; i++) m_mem[i] = '0;
    model_reset();

    // Directed program: fields, sign/zero extension, reg 0, memory, branches, far jump
    for (int i = 0; i < IW; i++) prog[i] = 32'h0;
    prog[0]  = enc_i(15, 0, 1, 16'ha532);      // R5 lui
    prog[1]  = enc_i(13, 1, 1, 16'h8d7e);      // R5 ori -> a5328d7e
    prog[2]  = enc_i(8, 0, 2, -5);             // R5 addi sign-extended
    prog[3]  = enc_i(12, 2, 3, 16'hff00);      // R5 andi zero-extended
    prog[4]  = enc_r(2, 3, 4, 0, 42);          // R3 slt signed -> 1
    prog[5]  = enc_i(10, 3, 5, -1);            // R5 slti -> 0
    prog[6]  = enc_r(7, 1, 6, 4, 0);           // R4 sll, rs ignored
    prog[7]  = enc_r(0, 1, 7, 28, 2);          // R4 srl -> a
    prog[8]  = enc_r(3, 2, 8, 0, 34);          // R3 sub
    prog[9]  = enc_r(2, 0, 9, 0, 39);          // R3 nor
    prog[10] = enc_i(8, 0, 0, 7);              // R9 write to reg 0
    prog[11] = enc_r(0, 0, 10, 0, 32);         // R9 reg 0 reads zero
    prog[12] = enc_i(8, 0, 11, 16);
    prog[13] = enc_i(43, 11, 1, -8);           // R6 sw at 16-8
    prog[14] = enc_i(35, 0, 12, 8);            // R6 lw from 8
    prog[15] = enc_i(4, 12, 1, 1);             // R7 beq taken
    prog[16] = enc_i(8, 0, 13, 1);             // skipped
    prog[17] = enc_i(5, 0, 0, 3);              // R7 bne not taken
    prog[18] = enc_j(1212);                    // R8 -> 4848, word 60
    prog[60] = enc_i(4, 0, 0, -3);             // R7 negative offset
    load_prog();
    reset_and_check(2);
    run(24);
    check("R8 far jump target", (dbg_pc == 32'd4848 || dbg_pc[31:12] == 20'h1) ? 32'd1 : 32'd0, 32'd1);

    // Random programs
    for (int p = 0; p < 3; p++) begin
      rst = 1'b1;
      for (int i = 0; i < 16; i++) prog[i] = enc_i(43, 0, 0, i * 4);
      for (int i = 16; i < IW; i++) prog[i] = rand_instr();
      load_prog();
      reset_and_check(2);
      run(300);
      reset_and_check(1);
      run(40);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule